// File: doc/BRIEF.md
# Passive Cell Balancing Selector

This block decides which bypass switches of a sixteen-cell series stack should conduct. In the automatic mode it looks at the per-cell voltages and turns on the cells that sit highest above the weakest cell. A cell qualifies only if it clears a programmable margin over the minimum and a programmable absolute floor. It never turns on two neighbouring cells, and it caps how many cells are on at once. In the host mode a software-supplied bit mask is followed directly, neighbours included, but it is still trimmed to the same cap.

A new selection is computed once per measurement loop, when the `loop_tick` strobe arrives. It is then held unchanged until the next completed computation. The automatic choice is made by a sequential scan that handles one candidate per clock. While the measurement front end reports that a conversion is running, every switch is forced off. The held selection comes back as soon as the conversion ends.

Top module: `cbal_top`

## Requirements
- R1: While `rst` is high, and after reset until the first selection completes, `bal_mask` is 0.
- R2: A `loop_tick` seen while the block is idle starts a selection. It uses the inputs sampled at that clock edge. The result appears on `bal_mask` after the 16th rising edge that follows the sampling edge. With no new selection, `bal_mask` stays unchanged even if the inputs change.
- R3: A `loop_tick` that arrives while a selection is still being computed is ignored. It neither restarts nor queues a selection.
- R4: In automatic mode (`mode_host`=0), cell i is a candidate when two conditions hold. Its voltage minus the stack minimum must be at least `delta_mv`. Its voltage must also be at least `floor_mv`. All values are unsigned millivolts, and cell i sits at `cell_v[16*i+15:16*i]`.
- R5: In automatic mode, candidates are considered in descending voltage order. Among equal voltages, the lower index comes first.
- R6: In automatic mode, a candidate is skipped when cell i-1 or cell i+1 is already selected. No two adjacent bits of the result are ever both set.
- R7: In automatic mode, at most `max_cnt` cells are selected. A `max_cnt` of 0 yields an empty selection.
- R8: In host mode (`mode_host`=1), bit i of `host_mask` enables cell i, and adjacent cells are allowed. Only the lowest-indexed `max_cnt` set bits are kept.
- R9: While `meas_busy` is 1, `bal_mask` is 0 in the same cycle. When it returns to 0, the held selection reappears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_v | input | 256 | Sixteen cell voltages in mV, cell i at bits 16*i+15:16*i |
| mode_host | input | 1 | 0 automatic, 1 host-commanded |
| host_mask | input | 16 | Host request, bit i for cell i |
| max_cnt | input | 5 | Maximum number of simultaneously active switches |
| delta_mv | input | 16 | Minimum excess over the stack minimum (automatic mode) |
| floor_mv | input | 16 | Minimum absolute cell voltage (automatic mode) |
| loop_tick | input | 1 | Once-per-loop recompute strobe |
| meas_busy | input | 1 | Measurement in progress; blanks all switches |
| bal_mask | output | 16 | Bypass switch enables, bit i for cell i |

## Verification
A selection result is due exactly sixteen rising edges after the edge that samples `loop_tick`. The bench counts those edges from the tick and reads `bal_mask` on the following falling edge. It also checks the value again many cycles later, to confirm that it holds. Blanking is combinational, so the bench checks it just after `meas_busy` changes on a falling edge, with no clock in between. The ignored-tick case places a second tick five edges into a scan. It then checks that the first scan's result appears on schedule and that no second result follows.

// File: rtl/cbal_pkg.sv
package cbal_pkg;

    localparam int CB_NCELL = 16;
    localparam int CB_VW    = 16;

    typedef enum logic {
        CB_AUTO = 1'b0,
        CB_HOST = 1'b1
    } cb_mode_e;

    typedef enum logic {
        SC_IDLE = 1'b0,
        SC_RUN  = 1'b1
    } cb_scan_e;

endpackage

// File: rtl/cbal_cand.sv
module cbal_cand #(
    parameter int NCELL = cbal_pkg::CB_NCELL,
    parameter int VW    = cbal_pkg::CB_VW
) (
    input  logic [NCELL-1:0][VW-1:0] volt,
    input  logic [VW-1:0]            delta,
    input  logic [VW-1:0]            floor_v,
    output logic [NCELL-1:0]         cand
);

    logic [VW-1:0] vmin;

    always_comb begin
        vmin = volt[0];
        for (int i = 1; i < NCELL; i++) begin
            if (volt[i] < vmin) vmin = volt[i];
        end
    end

    generate
        for (genvar g = 0; g < NCELL; g++) begin : g_cand
            assign cand[g] = ((volt[g] - vmin) >= delta) && (volt[g] >= floor_v);
        end
    endgenerate

endmodule

// File: rtl/cbal_host_trunc.sv
module cbal_host_trunc #(
    parameter int NCELL = cbal_pkg::CB_NCELL,
    parameter int CW    = $clog2(NCELL + 1)
) (
    input  logic [NCELL-1:0] req,
    input  logic [CW-1:0]    limit,
    output logic [NCELL-1:0] kept
);

    int unsigned taken;

    always_comb begin
        kept  = '0;
        taken = 0;
        for (int i = 0; i < NCELL; i++) begin
            if (req[i] && (taken < 32'(limit))) begin
                kept[i] = 1'b1;
                taken   = taken + 1;
            end
        end
    end

endmodule

// File: rtl/cbal_greedy.sv
module cbal_greedy
    import cbal_pkg::*;
#(
    parameter int NCELL = CB_NCELL,
    parameter int VW    = CB_VW,
    parameter int CW    = $clog2(NCELL + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [NCELL-1:0][VW-1:0] volt_in,
    input  logic [NCELL-1:0]         cand_in,
    input  logic [CW-1:0]            lim_in,
    output logic                     busy,
    output logic                     done,
    output logic [NCELL-1:0]         result
);

    localparam int IW = $clog2(NCELL);

    cb_scan_e                 st_q;
    logic [NCELL-1:0][VW-1:0] volt_q;
    logic [NCELL-1:0]         pend_q;
    logic [NCELL-1:0]         work_q;
    logic [CW-1:0]            cnt_q;
    logic [CW-1:0]            lim_q;
    logic [IW-1:0]            step_q;

    logic                     found;
    logic [IW-1:0]            best_idx;
    logic [VW-1:0]            best_v;
    logic [NCELL-1:0]         nbr;
    logic                     accept;
    logic [NCELL-1:0]         work_nx;

    // highest remaining candidate, strict compare keeps the lower index on ties
    always_comb begin
        found    = 1'b0;
        best_idx = '0;
        best_v   = '0;
        for (int i = 0; i < NCELL; i++) begin
            if (pend_q[i] && (!found || (volt_q[i] > best_v))) begin
                found    = 1'b1;
                best_idx = IW'(i);
                best_v   = volt_q[i];
            end
        end
    end

    assign nbr     = (work_q << 1) | (work_q >> 1);
    assign accept  = found && (cnt_q < lim_q) && !nbr[best_idx];
    assign work_nx = accept ? (work_q | (NCELL'(1) << best_idx)) : work_q;
    assign busy    = (st_q == SC_RUN);
    assign done    = busy && (step_q == IW'(NCELL - 1));
    assign result  = work_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SC_IDLE;
            volt_q <= '0;
            pend_q <= '0;
            work_q <= '0;
            cnt_q  <= '0;
            lim_q  <= '0;
            step_q <= '0;
        end else if (start && !busy) begin
            st_q   <= SC_RUN;
            volt_q <= volt_in;
            pend_q <= cand_in;
            work_q <= '0;
            cnt_q  <= '0;
            lim_q  <= lim_in;
            step_q <= '0;
        end else if (busy) begin
            if (found) pend_q[best_idx] <= 1'b0;
            work_q <= work_nx;
            if (accept) cnt_q <= cnt_q + 1'b1;
            step_q <= step_q + 1'b1;
            if (done) st_q <= SC_IDLE;
        end
    end

    // R6
    adj_free_chk: assert property (@(posedge clk) disable iff (rst)
        ((work_q & (work_q >> 1)) == '0));

    // R7
    cnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(work_q) <= int'(lim_q)));

endmodule

// File: rtl/cbal_top.sv
module cbal_top
    import cbal_pkg::*;
#(
    parameter int NCELL = CB_NCELL,
    parameter int VW    = CB_VW,
    parameter int CW    = $clog2(NCELL + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NCELL*VW-1:0] cell_v,
    input  logic                mode_host,
    input  logic [NCELL-1:0]    host_mask,
    input  logic [CW-1:0]       max_cnt,
    input  logic [VW-1:0]       delta_mv,
    input  logic [VW-1:0]       floor_mv,
    input  logic                loop_tick,
    input  logic                meas_busy,
    output logic [NCELL-1:0]    bal_mask
);

    logic [NCELL-1:0][VW-1:0] volt;
    logic [NCELL-1:0]         cand;
    logic [NCELL-1:0]         host_kept;
    logic [NCELL-1:0]         auto_sel;
    logic                     busy;
    logic                     done;
    logic                     start;

    cb_mode_e                 mode_q;
    logic [NCELL-1:0]         host_q;
    logic [NCELL-1:0]         sel_q;

    generate
        for (genvar g = 0; g < NCELL; g++) begin : g_unpack
            assign volt[g] = cell_v[g*VW +: VW];
        end
    endgenerate

    assign start = loop_tick && !busy;

    cbal_cand #(.NCELL(NCELL), .VW(VW)) u_cand (
        .volt    (volt),
        .delta   (delta_mv),
        .floor_v (floor_mv),
        .cand    (cand)
    );

    cbal_host_trunc #(.NCELL(NCELL), .CW(CW)) u_trunc (
        .req   (host_mask),
        .limit (max_cnt),
        .kept  (host_kept)
    );

    cbal_greedy #(.NCELL(NCELL), .VW(VW), .CW(CW)) u_greedy (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .volt_in (volt),
        .cand_in (cand),
        .lim_in  (max_cnt),
        .busy    (busy),
        .done    (done),
        .result  (auto_sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= CB_AUTO;
            host_q <= '0;
            sel_q  <= '0;
        end else begin
            if (start) begin
                mode_q <= cb_mode_e'(mode_host);
                host_q <= host_kept;
            end
            if (done) sel_q <= (mode_q == CB_HOST) ? host_q : auto_sel;
        end
    end

    assign bal_mask = meas_busy ? '0 : sel_q;

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(sel_q));

    // R8
    host_subset_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> ((host_q & ~$past(host_mask)) == '0));

    // R8
    host_cap_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> ($countones(host_q) <= int'($past(max_cnt))));

endmodule

// File: tb/sim_cbal_top.sv
module sim_cbal_top;

    typedef struct packed {
        logic        host;
        logic [15:0] base;
        logic [19:0] oi;
        logic [79:0] ov;
        logic [15:0] hm;
        logic [4:0]  mx;
        logic [15:0] dl;
        logic [15:0] fl;
        logic [15:0] ex;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VT [NV] = '{
        '{1'b0, 16'd3600, {4'd0,4'd0,4'd9,4'd6,4'd5}, {16'd0,16'd0,16'd3650,16'd3690,16'd3700},
          16'h0000, 5'd4,  16'd20, 16'd3000, 16'h0220},
        '{1'b0, 16'd3600, {4'd9,4'd7,4'd5,4'd3,4'd1}, {16'd3760,16'd3770,16'd3780,16'd3790,16'd3800},
          16'h0000, 5'd3,  16'd20, 16'd3000, 16'h002A},
        '{1'b0, 16'd3600, {4'd0,4'd0,4'd4,4'd3,4'd2}, {16'd0,16'd0,16'd3700,16'd3700,16'd3700},
          16'h0000, 5'd16, 16'd20, 16'd3000, 16'h0014},
        '{1'b0, 16'd3600, {4'd0,4'd0,4'd0,4'd15,4'd0}, {16'd0,16'd0,16'd0,16'd3625,16'd3615},
          16'h0000, 5'd16, 16'd20, 16'd3000, 16'h8000},
        '{1'b0, 16'd2800, {4'd0,4'd0,4'd0,4'd10,4'd8}, {16'd0,16'd0,16'd0,16'd3100,16'd2900},
          16'h0000, 5'd16, 16'd20, 16'd3000, 16'h0400},
        '{1'b1, 16'd3600, 20'd0, 80'd0, 16'h0007, 5'd16, 16'd20, 16'd3000, 16'h0007},
        '{1'b1, 16'd3600, 20'd0, 80'd0, 16'hF0F0, 5'd3,  16'd20, 16'd3000, 16'h0070},
        '{1'b1, 16'd3600, 20'd0, 80'd0, 16'hFFFF, 5'd0,  16'd20, 16'd3000, 16'h0000},
        '{1'b0, 16'd3600, 20'd0, 80'd0, 16'h0000, 5'd16, 16'd0,  16'd0,    16'h5555},
        '{1'b0, 16'd3600, {4'd0,4'd0,4'd9,4'd6,4'd5}, {16'd0,16'd0,16'd3650,16'd3690,16'd3700},
          16'h0000, 5'd0,  16'd20, 16'd3000, 16'h0000}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [255:0] cell_v = '0;
    logic         mode_host = 1'b0;
    logic [15:0]  host_mask = '0;
    logic [4:0]   max_cnt = '0;
    logic [15:0]  delta_mv = '0;
    logic [15:0]  floor_mv = '0;
    logic         loop_tick = 1'b0;
    logic         meas_busy = 1'b0;
    logic [15:0]  bal_mask;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cbal_top u0 (
        .clk       (clk),
        .rst       (rst),
        .cell_v    (cell_v),
        .mode_host (mode_host),
        .host_mask (host_mask),
        .max_cnt   (max_cnt),
        .delta_mv  (delta_mv),
        .floor_mv  (floor_mv),
        .loop_tick (loop_tick),
        .meas_busy (meas_busy),
        .bal_mask  (bal_mask)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic load(input vec_t t);
        logic [255:0] v;
        v = {16{t.base}};
        for (int k = 0; k < 5; k++) begin
            if (t.ov[k*16 +: 16] != 16'd0) begin
                int idx;
                idx = int'(t.oi[k*4 +: 4]);
                v[idx*16 +: 16] = t.ov[k*16 +: 16];
            end
        end
        cell_v    = v;
        mode_host = t.host;
        host_mask = t.hm;
        max_cnt   = t.mx;
        delta_mv  = t.dl;
        floor_mv  = t.fl;
    endtask

    // called on a falling edge; returns on the falling edge after the result edge
    task automatic run(input vec_t t);
        load(t);
        loop_tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        loop_tick = 1'b0;
        repeat (16) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 during reset", bal_mask, 16'h0000);
        rst = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R1 after reset, no selection yet", bal_mask, 16'h0000);

        // table: R4/R5/R6/R7/R8 via vector contents
        for (int n = 0; n < NV; n++) begin
            run(VT[n]);
            chk($sformatf("R4/R5/R6/R7/R8 vector %0d", n), bal_mask, VT[n].ex);
        end

        // R2 hold: inputs change without a tick
        run(VT[0]);
        chk("R2 fresh selection", bal_mask, 16'h0220);
        load(VT[2]);
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk("R2 held without tick", bal_mask, 16'h0220);

        // R2 latency: one edge early the old value must still be present
        run(VT[2]);
        chk("R2 second selection", bal_mask, 16'h0014);
        load(VT[1]);
        loop_tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        loop_tick = 1'b0;
        repeat (15) @(posedge clk);
        @(negedge clk);
        chk("R2 not yet updated at 15 edges", bal_mask, 16'h0014);
        @(posedge clk);
        @(negedge clk);
        chk("R2 updated at 16 edges", bal_mask, 16'h002A);

        // R3 tick during a scan is ignored
        run(VT[2]);
        chk("R3 setup", bal_mask, 16'h0014);
        load(VT[0]);
        loop_tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        loop_tick = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        load(VT[1]);
        loop_tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        loop_tick = 1'b0;
        repeat (11) @(posedge clk);
        @(negedge clk);
        chk("R3 first scan completes on time", bal_mask, 16'h0220);
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk("R3 no queued second scan", bal_mask, 16'h0220);

        // R9 blanking
        meas_busy = 1'b1;
        #1;
        chk("R9 blanked while measuring", bal_mask, 16'h0000);
        @(posedge clk);
        @(negedge clk);
        chk("R9 still blanked next cycle", bal_mask, 16'h0000);
        meas_busy = 1'b0;
        #1;
        chk("R9 restored after measurement", bal_mask, 16'h0220);

        // R9 host mode adjacency plus blanking
        run(VT[5]);
        meas_busy = 1'b1;
        #1;
        chk("R9 host selection blanked", bal_mask, 16'h0000);
        meas_busy = 1'b0;
        #1;
        chk("R8 host adjacent cells restored", bal_mask, 16'h0007);

        summary();
        $finish;
    end

endmodule